// File: doc/BRIEF.md
# Cascade Extension Counter with Read-Synchronized Snapshot

This block widens a position count past its low-order word. A narrow up/down counter advances once for every cascade pulse that the low-order counter emits when it wraps, and the direction input from that counter chooses whether it counts up or down. The host reads the full position several bytes at a time. The low-order word is frozen when the read begins, so the extension byte has to be frozen at that same moment, or the bytes will not belong to the same count.

A snapshot register takes the extension count at the clock edge where a read begins. A read begins on the first cycle in which the select and output-enable inputs are both low. A cascade pulse that arrives on that same edge still goes into the live counter. The snapshot, however, keeps the value from before that pulse, which is the value that matches the frozen low-order word. The snapshot does not change for the rest of the read and is taken again only after output enable has gone high and a new read has begun. The read port is a plain bus with no handshake and no back-pressure. The host decides when to read and is never stalled.

Top module: `casx_extend`

## Requirements
- R1: A synchronous reset sets both the live count and the snapshot to zero, so a read right after reset returns 0.
- R2: A cascade pulse sampled with the direction input high adds one to the live count, and the count wraps from 255 to 0.
- R3: A cascade pulse sampled with the direction input low subtracts one from the live count, and the count wraps from 0 to 255.
- R4: On a cycle with no cascade pulse, the live count does not change.
- R5: The snapshot is taken on the clock edge where select_n and oe_n are first both low. It holds the count from before any pulse on that edge, so from 0xF0 with a pulse it reads 0xF0, not 0xF1.
- R6: A cascade pulse on the edge where a read begins is still counted, so the next read returns the stepped value.
- R7: While oe_n stays low, the snapshot keeps its value through any cascade pulses and through select_n going high and low again. A new snapshot is taken only after oe_n has returned high.
- R8: rd_data is 0 unless select_n and oe_n are both low. When both are low, rd_data shows the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| casc_pulse | input | 1 | One-cycle cascade pulse from the low-order counter |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| select_n | input | 1 | Extension byte selected when low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 8 | Snapshot byte when selected and enabled, otherwise 0 |

## Verification
A pulse or a read start presented before a rising edge takes effect on that edge. The new live count and the new snapshot can therefore be seen at rd_data at the next falling edge. rd_data depends combinationally on the snapshot and the two enables, so any change in the enables shows up in the same cycle. The bench drives every input on a falling edge, lets exactly one rising edge pass, and compares at the following falling edge. It computes the expected values from a modular model of the count kept in the bench itself.

// File: rtl/casx_pkg.sv
package casx_pkg;
  localparam int unsigned EXT_W = 8;
  typedef logic [EXT_W-1:0] ext_t;
endpackage

// File: rtl/casx_counter.sv
module casx_counter #(
  parameter int unsigned W = casx_pkg::EXT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (step) count_q <= up ? count_q + UNIT : count_q - UNIT;
  end

  assign count = count_q;
endmodule

// File: rtl/casx_snap.sv
module casx_snap #(
  parameter int unsigned W = casx_pkg::EXT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         select_n,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap,
  output logic         take,
  output logic         frozen
);
  logic [W-1:0] snap_q;
  logic         frozen_q;
  logic         reading;

  assign reading = !select_n && !oe_n;
  assign take    = reading && !frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (take) snap_q <= live;
      if (oe_n)      frozen_q <= 1'b0;
      else if (take) frozen_q <= 1'b1;
    end
  end

  assign snap   = snap_q;
  assign frozen = frozen_q;
endmodule

// File: rtl/casx_outmux.sv
module casx_outmux #(
  parameter int unsigned W = casx_pkg::EXT_W
) (
  input  logic         select_n,
  input  logic         oe_n,
  input  logic [W-1:0] snap,
  output logic [W-1:0] bus
);
  always_comb begin
    bus = '0;
    if (!select_n && !oe_n) bus = snap;
  end
endmodule

// File: rtl/casx_extend.sv
module casx_extend (
  input  logic       clk,
  input  logic       rst,
  input  logic       casc_pulse,
  input  logic       count_up,
  input  logic       select_n,
  input  logic       oe_n,
  output logic [7:0] rd_data
);
  import casx_pkg::*;

  ext_t live_cnt;
  ext_t snap_val;
  logic snap_take;
  logic snap_frozen;

  casx_counter #(.W(EXT_W)) u_counter (
    .clk(clk), .rst(rst), .step(casc_pulse), .up(count_up), .count(live_cnt)
  );

  casx_snap #(.W(EXT_W)) u_snap (
    .clk(clk), .rst(rst), .select_n(select_n), .oe_n(oe_n), .live(live_cnt),
    .snap(snap_val), .take(snap_take), .frozen(snap_frozen)
  );

  casx_outmux #(.W(EXT_W)) u_mux (
    .select_n(select_n), .oe_n(oe_n), .snap(snap_val), .bus(rd_data)
  );
endmodule

// File: rtl/casx_extend_chk.sv
module casx_extend_chk (
  input logic       clk,
  input logic       rst,
  input logic       casc_pulse,
  input logic       count_up,
  input logic       select_n,
  input logic       oe_n,
  input logic [7:0] rd_data,
  input logic [7:0] live_cnt,
  input logic [7:0] snap_val,
  input logic       snap_take
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (live_cnt == 8'd0 && snap_val == 8'd0));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (casc_pulse && count_up) |=> (live_cnt == 8'($past(live_cnt) + 8'd1)));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (casc_pulse && !count_up) |=> (live_cnt == 8'($past(live_cnt) - 8'd1)));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !casc_pulse |=> $stable(live_cnt));

  assert_snap_prior_R5: assert property (@(posedge clk) disable iff (rst)
    (!select_n && !oe_n && snap_take) |=> (snap_val == $past(live_cnt)));

  assert_snap_held_R7: assert property (@(posedge clk) disable iff (rst)
    !snap_take |=> $stable(snap_val));

  assert_bus_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (select_n || oe_n) |-> (rd_data == 8'd0));
endmodule

bind casx_extend casx_extend_chk u_chk (
  .clk(clk), .rst(rst), .casc_pulse(casc_pulse), .count_up(count_up),
  .select_n(select_n), .oe_n(oe_n), .rd_data(rd_data),
  .live_cnt(live_cnt), .snap_val(snap_val), .snap_take(snap_take)
);

// File: tb/test_casx_extend.sv
module test_casx_extend;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       casc_pulse;
  logic       count_up;
  logic       select_n;
  logic       oe_n;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [7:0] cnt_m;
  logic [7:0] snap_m;

  always #(CLK_NS/2) clk = ~clk;

  casx_extend i_casx_extend (
    .clk(clk), .rst(rst), .casc_pulse(casc_pulse), .count_up(count_up),
    .select_n(select_n), .oe_n(oe_n), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic up, input logic sn, input logic oen);
    casc_pulse = p; count_up = up; select_n = sn; oe_n = oen;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bump(input logic up);
    cyc(1'b1, up, 1'b1, 1'b1);
    cnt_m = up ? cnt_m + 8'd1 : cnt_m - 8'd1;
  endtask

  // start a read (optional pulse on the start edge), compare, then release
  task automatic rd(input string req, input logic p, input logic up);
    cyc(p, up, 1'b0, 1'b0);
    snap_m = cnt_m;
    if (p) cnt_m = up ? cnt_m + 8'd1 : cnt_m - 8'd1;
    check(req, rd_data, snap_m);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    check("R8", rd_data, 8'd0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog: rd_data=%0h expected=done", rd_data);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; casc_pulse = 1'b0; count_up = 1'b0; select_n = 1'b1; oe_n = 1'b1;
    cnt_m = 8'd0; snap_m = 8'd0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd("R1", 1'b0, 1'b0);

    // R2: up sweep across the wrap, read after each step
    for (int i = 0; i < 300; i++) begin
      bump(1'b1);
      rd("R2", 1'b0, 1'b0);
    end
    // R3: down sweep across the wrap
    for (int i = 0; i < 300; i++) begin
      bump(1'b0);
      rd("R3", 1'b0, 1'b0);
    end
    // R4: idle cycles keep the count
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1);
    rd("R4", 1'b0, 1'b0);

    // R5/R6: read start coinciding with a pulse, from every start value, both directions
    for (int v = 0; v < 256; v++) begin
      while (cnt_m != 8'(v)) bump(1'b1);
      rd("R5", 1'b1, v[0]);
      rd("R6", 1'b0, 1'b0);
    end
    // R5: the 0xF0 case explicitly
    while (cnt_m != 8'hF0) bump(1'b1);
    rd("R5", 1'b1, 1'b1);
    check("R5", snap_m, 8'hF0);
    rd("R6", 1'b0, 1'b0);
    check("R6", snap_m, 8'hF1);

    // R7: snapshot held through pulses and select toggling while oe_n low
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    snap_m = cnt_m;
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b0);
      cnt_m = cnt_m + 8'd1;
      check("R7", rd_data, snap_m);
    end
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    cnt_m = cnt_m + 8'd1;
    check("R8", rd_data, 8'd0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check("R7", rd_data, snap_m);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    rd("R7", 1'b0, 1'b0);

    // R8: select low with oe_n high, and oe_n low with select high
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8", rd_data, 8'd0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8", rd_data, 8'd0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);

    // R1: reset mid-count
    rst = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    rst = 1'b0;
    cnt_m = 8'd0;
    rd("R1", 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule